// File: doc/BRIEF.md
# Reset Time-out Sequencer with Cause Flags

This block decides when a small processor may begin executing after a reset and records why that reset happened. It receives one-cycle event pulses from the power-on detector, the brown-out detector, the watchdog and the wake-up logic. It also receives the level of the external master-reset pin and a flag that says the core is asleep. After a power event it runs two delays in order: a power-up delay, whose length is a parameter counted in clock cycles, then an oscillator start-up delay of 1024 periods. Only when both have finished and the master-reset pin is high does the run enable go active.

Both delays start from the power event itself. A master-reset pin held low does not postpone them, so releasing the pin after they have expired starts execution one cycle later. The power-up delay can be turned off by a configuration input. The oscillator delay is used only with crystal-type oscillator modes. A wake from sleep applies only the oscillator delay, and only in those modes.

Four cause flags are kept: power-on, brown-out, time-out and power-down. Each reset kind sets, clears or keeps each flag by a fixed rule. Software reads and writes the power-on and brown-out flags through an 8-bit power-control port. The time-out and power-down flags are read-only outputs.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes this state after that edge: `seq_state`=0 (IDLE), `run_en`=0, `pcon_rdata`=8'h00, `flag_to`=1 and `flag_pd`=1.
- R2: With `cfg_pwrt_en`=1, a power event (`por_pulse` or `bor_pulse` high at an edge) puts `seq_state` at 1 (PWRT) from that edge on, for exactly PWRT_CYCLES cycles.
- R3: The oscillator stage (`seq_state`=2, OST) lasts exactly OST_CYCLES cycles and follows the power-up stage, or follows the event directly when `cfg_pwrt_en`=0. It is used only for `cfg_osc_mode` 0, 1 or 2 (the crystal modes LP, XT and HS). It is skipped for modes 3 to 7 (RC, external clock, internal oscillator and the spare codes).
- R4: With `cfg_pwrt_en`=0, a non-crystal mode and `mclr_n`=1, a power event gives `seq_state`=3 (RUN) and `run_en`=1 right after the event edge.
- R5: The delays run even when `mclr_n` is low. When they end with `mclr_n` low, the state becomes IDLE. The first edge that samples `mclr_n`=1 then moves the state to RUN, with no further delay.
- R6: In RUN, `mclr_n` low at an edge moves the state to IDLE, and both flags stay unchanged when the core is awake. A falling edge of `mclr_n` while `cpu_sleep`=1 sets `flag_to`=1 and clears `flag_pd`=0.
- R7: While `cpu_sleep`=1 in RUN, a wake pulse in a crystal mode moves the state to OST for OST_CYCLES cycles and then back to RUN, never through PWRT. In a non-crystal mode the state stays RUN.
- R8: A watchdog pulse with `cpu_sleep`=0 clears `flag_to`, keeps `flag_pd`, and from RUN gives one IDLE cycle before RUN returns while `mclr_n`=1.
- R9: A watchdog pulse with `cpu_sleep`=1 clears both `flag_to` and `flag_pd`, and starts the wake-up sequence of R7.
- R10: A power-on pulse clears the power-on flag (`pcon_rdata` bit 1) and leaves the brown-out flag (bit 0) as it was. A brown-out pulse clears bit 0 and leaves bit 1. Either pulse sets `flag_to`=1 and `flag_pd`=1. When both pulses come together, both bits clear.
- R11: A write (`pcon_wr`=1) loads bits 1:0 of `pcon_wdata` into the power-on and brown-out flags, and bits 7:2 of `pcon_rdata` always read 0. A power event in the same cycle overrides the write for the flag it clears.
- R12: A power event during any stage, including PWRT or OST, restarts the sequence from its first stage with a full-length count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_pulse | input | 1 | Power-on detected, one-cycle pulse |
| bor_pulse | input | 1 | Brown-out detected, one-cycle pulse |
| mclr_n | input | 1 | External master-reset level, active low |
| wdt_pulse | input | 1 | Watchdog time-out, one-cycle pulse |
| wake_pulse | input | 1 | Wake-from-sleep request, one-cycle pulse |
| cpu_sleep | input | 1 | Core is in sleep |
| cfg_osc_mode | input | 3 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 RC, 4 EC, 5 internal oscillator, 6 and 7 spare |
| cfg_pwrt_en | input | 1 | Power-up delay enable |
| pcon_wr | input | 1 | Write strobe for the power-control port |
| pcon_wdata | input | 8 | Write data; bit 1 is power-on, bit 0 is brown-out |
| pcon_rdata | output | 8 | Read data: {6'b0, power-on flag, brown-out flag} |
| flag_to | output | 1 | Time-out flag |
| flag_pd | output | 1 | Power-down flag |
| run_en | output | 1 | Execution enable for the core |
| seq_state | output | 2 | Sequencer state: 0 IDLE, 1 PWRT, 2 OST, 3 RUN |

## Verification
The bench runs a power-on under all eight oscillator codes, each with the power-up delay on and off. It measures how long each stage lasts and where the sequence ends. A design that counted from the release of the master-reset pin, or that applied the oscillator delay to the wrong modes, would show stage lengths off by hundreds of cycles. The bench also checks the sleep-dependent cases, where the same pin or watchdog pulse must touch the time-out and power-down flags differently. It checks a power event that lands in the middle of a delay, which must restart the full count. It checks a register write that collides with a brown-out, where the event must win.

// File: rtl/rst_seq_pkg.sv
// Package: shared state encoding and oscillator-mode helpers for the reset
// time-out sequencer. Assumes a 3-bit oscillator mode from configuration.
package rst_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PWRT = 2'd1,
        SEQ_OST  = 2'd2,
        SEQ_RUN  = 2'd3
    } seq_state_t;

    localparam int OSC_MODE_W = 3;

    localparam logic [OSC_MODE_W-1:0] OSC_LP = 3'd0;
    localparam logic [OSC_MODE_W-1:0] OSC_XT = 3'd1;
    localparam logic [OSC_MODE_W-1:0] OSC_HS = 3'd2;

    // Crystal-type modes need the oscillator start-up delay.
    function automatic logic is_crystal(input logic [OSC_MODE_W-1:0] mode);
        return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
    endfunction

endpackage

// File: rtl/rst_delay_counter.sv
// Module: stage delay counter. Counts clock cycles while its stage is active
// and flags the last cycle of a LIMIT-cycle window. Assumes LIMIT >= 2 and
// that the owning FSM leaves the stage on the flagged cycle.
module rst_delay_counter #(
    parameter int LIMIT = 16,
    localparam int CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    output logic last
);

    logic [CW-1:0] cnt;

    // Advance while active; clear when idle or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final cycle of the window.
    always_comb begin
        last = active && (cnt == CW'(LIMIT - 1));
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(cnt) < LIMIT))
        else $error("delay counter ran beyond its window");

endmodule

// File: rtl/rst_cause_flags.sv
// Module: reset-cause flags. Holds the power-on, brown-out, time-out and
// power-down flags and the software port for the first two. Assumes event
// inputs are single-cycle and already decoded by sleep state.
module rst_cause_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_evt,
    input  logic          bor_evt,
    input  logic          wdt_reset,
    input  logic          wdt_wake,
    input  logic          mclr_sleep,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          to_flag,
    output logic          pd_flag
);

    logic por_flag;
    logic bor_flag;
    logic pwr_evt;

    // Any power event.
    always_comb begin
        pwr_evt = por_evt | bor_evt;
    end

    // Software flags: write first, events override afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_flag <= 1'b0;
            bor_flag <= 1'b0;
        end else begin
            if (wr_en) begin
                por_flag <= wr_data[1];
                bor_flag <= wr_data[0];
            end
            if (bor_evt) begin
                bor_flag <= 1'b0;
            end
            if (por_evt) begin
                por_flag <= 1'b0;
            end
        end
    end

    // Time-out and power-down flags by reset kind, power events first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b1;
            pd_flag <= 1'b1;
        end else if (pwr_evt) begin
            to_flag <= 1'b1;
            pd_flag <= 1'b1;
        end else if (wdt_reset) begin
            to_flag <= 1'b0;
        end else if (wdt_wake) begin
            to_flag <= 1'b0;
            pd_flag <= 1'b0;
        end else if (mclr_sleep) begin
            to_flag <= 1'b1;
            pd_flag <= 1'b0;
        end
    end

    // Read view: upper bits are unused.
    always_comb begin
        rd_data    = '0;
        rd_data[1] = por_flag;
        rd_data[0] = bor_flag;
    end

    // R10
    pwr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> (!rd_data[1] && to_flag && pd_flag))
        else $error("power-on did not set its flags");

    // R8
    wdt_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset && !pwr_evt) |=> (!to_flag && $stable(pd_flag)))
        else $error("watchdog reset flags wrong");

    // R6
    mclr_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mclr_sleep && !pwr_evt && !wdt_reset && !wdt_wake) |=> (to_flag && !pd_flag))
        else $error("master reset in sleep flags wrong");

endmodule

// File: rtl/rst_seq_fsm.sv
// Module: start-up sequencer state machine. Chains the power-up and
// oscillator stages after a power event, gates release on the master-reset
// pin, and handles watchdog reset and wake-up. Assumes configuration inputs
// are static while a stage runs.
module rst_seq_fsm
    import rst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_evt,
    input  logic       mclr_n,
    input  logic       wdt_reset,
    input  logic       wake_req,
    input  logic       xtal,
    input  logic       pwrt_en,
    input  logic       pwrt_last,
    input  logic       ost_last,
    output seq_state_t state,
    output logic       timeouts_done
);

    seq_state_t state_nx;
    seq_state_t finish_st;
    seq_state_t first_st;
    logic       done_nx;

    // Where a finished sequence lands and where a new one starts.
    always_comb begin
        finish_st = mclr_n ? SEQ_RUN : SEQ_IDLE;
        if (pwrt_en) begin
            first_st = SEQ_PWRT;
        end else if (xtal) begin
            first_st = SEQ_OST;
        end else begin
            first_st = finish_st;
        end
    end

    // Next-state decision, power events take priority over all else.
    always_comb begin
        state_nx = state;
        done_nx  = timeouts_done;
        if (pwr_evt) begin
            state_nx = first_st;
            done_nx  = !(pwrt_en || xtal);
        end else begin
            unique case (state)
                SEQ_PWRT: begin
                    if (pwrt_last) begin
                        state_nx = xtal ? SEQ_OST : finish_st;
                        done_nx  = !xtal;
                    end
                end
                SEQ_OST: begin
                    if (ost_last) begin
                        state_nx = finish_st;
                        done_nx  = 1'b1;
                    end
                end
                SEQ_IDLE: begin
                    if (timeouts_done && mclr_n) begin
                        state_nx = SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (!mclr_n || wdt_reset) begin
                        state_nx = SEQ_IDLE;
                    end else if (wake_req && xtal) begin
                        state_nx = SEQ_OST;
                    end
                end
                default: state_nx = SEQ_IDLE;
            endcase
        end
    end

    // State and completion registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SEQ_IDLE;
            timeouts_done <= 1'b0;
        end else begin
            state         <= state_nx;
            timeouts_done <= done_nx;
        end
    end

    // R2
    pwrt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_PWRT && !pwr_evt && !pwrt_last) |=> (state == SEQ_PWRT))
        else $error("power-up stage left early");

    // R3
    ost_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OST) |-> xtal)
        else $error("oscillator stage in non-crystal mode");

    // R5
    run_mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> $past(mclr_n))
        else $error("run entered with master reset low");

    // R12
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_evt && pwrt_en) |=> (state == SEQ_PWRT))
        else $error("power event did not restart the sequence");

endmodule

// File: rtl/rst_timeout_seq.sv
// Module: reset time-out sequencer top. Decodes raw reset events by sleep
// state, runs the chained start-up delays and keeps the cause flags.
// Assumes event pulses are synchronous to clk and one cycle wide.
module rst_timeout_seq
    import rst_seq_pkg::*;
#(
    parameter int PWRT_CYCLES = 4096,
    parameter int OST_CYCLES  = 1024,
    parameter int PCON_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  por_pulse,
    input  logic                  bor_pulse,
    input  logic                  mclr_n,
    input  logic                  wdt_pulse,
    input  logic                  wake_pulse,
    input  logic                  cpu_sleep,
    input  logic [OSC_MODE_W-1:0] cfg_osc_mode,
    input  logic                  cfg_pwrt_en,
    input  logic                  pcon_wr,
    input  logic [PCON_W-1:0]     pcon_wdata,
    output logic [PCON_W-1:0]     pcon_rdata,
    output logic                  flag_to,
    output logic                  flag_pd,
    output logic                  run_en,
    output logic [1:0]            seq_state
);

    logic       mclr_q;
    logic       mclr_fall;
    logic       pwr_evt;
    logic       wdt_reset;
    logic       wdt_wake;
    logic       mclr_sleep;
    logic       wake_req;
    logic       xtal;
    logic       pwrt_last;
    logic       ost_last;
    logic       done;
    seq_state_t state;

    // Previous master-reset level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mclr_q <= 1'b1;
        end else begin
            mclr_q <= mclr_n;
        end
    end

    // Classify raw events by sleep state.
    always_comb begin
        mclr_fall  = mclr_q && !mclr_n;
        pwr_evt    = por_pulse | bor_pulse;
        wdt_reset  = wdt_pulse && !cpu_sleep;
        wdt_wake   = wdt_pulse && cpu_sleep;
        mclr_sleep = mclr_fall && cpu_sleep;
        wake_req   = cpu_sleep && (wake_pulse || wdt_pulse);
        xtal       = is_crystal(cfg_osc_mode);
    end

    rst_delay_counter #(.LIMIT(PWRT_CYCLES)) i_pwrt_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == SEQ_PWRT),
        .restart (pwr_evt),
        .last    (pwrt_last)
    );

    rst_delay_counter #(.LIMIT(OST_CYCLES)) i_ost_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == SEQ_OST),
        .restart (pwr_evt),
        .last    (ost_last)
    );

    rst_seq_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_evt       (pwr_evt),
        .mclr_n        (mclr_n),
        .wdt_reset     (wdt_reset),
        .wake_req      (wake_req),
        .xtal          (xtal),
        .pwrt_en       (cfg_pwrt_en),
        .pwrt_last     (pwrt_last),
        .ost_last      (ost_last),
        .state         (state),
        .timeouts_done (done)
    );

    rst_cause_flags #(.DW(PCON_W)) i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_evt    (por_pulse),
        .bor_evt    (bor_pulse),
        .wdt_reset  (wdt_reset),
        .wdt_wake   (wdt_wake),
        .mclr_sleep (mclr_sleep),
        .wr_en      (pcon_wr),
        .wr_data    (pcon_wdata),
        .rd_data    (pcon_rdata),
        .to_flag    (flag_to),
        .pd_flag    (flag_pd)
    );

    // Drive the status outputs.
    always_comb begin
        seq_state = state;
        run_en    = (state == SEQ_RUN);
    end

    // R7
    wake_no_pwrt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && !pwr_evt) |=> (state != SEQ_PWRT))
        else $error("wake or run path entered power-up stage");

endmodule

// File: tb/test_rst_timeout_seq.sv
module test_rst_timeout_seq;

    localparam int P = 16;
    localparam int O = 1024;

    logic       clk = 1'b0;
    logic       rst_n, por_pulse, bor_pulse, mclr_n, wdt_pulse, wake_pulse, cpu_sleep;
    logic [2:0] cfg_osc_mode;
    logic       cfg_pwrt_en, pcon_wr;
    logic [7:0] pcon_wdata, pcon_rdata;
    logic       flag_to, flag_pd, run_en;
    logic [1:0] seq_state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rst_timeout_seq #(.PWRT_CYCLES(P), .OST_CYCLES(O)) i_rst_timeout_seq (
        .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .bor_pulse(bor_pulse),
        .mclr_n(mclr_n), .wdt_pulse(wdt_pulse), .wake_pulse(wake_pulse),
        .cpu_sleep(cpu_sleep), .cfg_osc_mode(cfg_osc_mode), .cfg_pwrt_en(cfg_pwrt_en),
        .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata), .pcon_rdata(pcon_rdata),
        .flag_to(flag_to), .flag_pd(flag_pd), .run_en(run_en), .seq_state(seq_state)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic pulse_por();
        por_pulse = 1'b1;
        step();
        por_pulse = 1'b0;
    endtask

    task automatic measure(input logic [1:0] s, output int n);
        n = 0;
        while (seq_state == s && n < 4000) begin
            n++;
            step();
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 0; por_pulse = 0; bor_pulse = 0; mclr_n = 1; wdt_pulse = 0;
        wake_pulse = 0; cpu_sleep = 0; cfg_osc_mode = 3'd1; cfg_pwrt_en = 1;
        pcon_wr = 0; pcon_wdata = 8'h00;
        step();
        step();
        // R1 reset state
        check("R1 state", seq_state, 0);
        check("R1 run_en", run_en, 0);
        check("R1 pcon", pcon_rdata, 0);
        check("R1 to", flag_to, 1);
        check("R1 pd", flag_pd, 1);
        rst_n = 1;
        step();

        // R2 R3 R4 sweep over all modes and the power-up enable
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 2; e++) begin
                int xt;
                xt = (m <= 2) ? 1 : 0;
                cfg_osc_mode = 3'(m);
                cfg_pwrt_en = e[0];
                do_reset();
                pulse_por();
                if (e == 0 && xt == 0) check("R4 immediate run", run_en, 1);
                measure(2'd1, n);
                check($sformatf("R2 pwrt len m%0d e%0d", m, e), n, e ? P : 0);
                measure(2'd2, n);
                check($sformatf("R3 ost len m%0d e%0d", m, e), n, xt ? O : 0);
                check("R3 final run", seq_state, 3);
                check("R10 por flags", {pcon_rdata, flag_to, flag_pd}, 3);
            end
        end

        // R5 master reset held through both delays
        cfg_osc_mode = 3'd2; cfg_pwrt_en = 1;
        do_reset();
        mclr_n = 0;
        pulse_por();
        repeat (P + O + 20) step();
        check("R5 held idle", seq_state, 0);
        mclr_n = 1;
        step();
        check("R5 run one edge after release", seq_state, 3);

        // R11 software port
        pcon_wr = 1; pcon_wdata = 8'hFF;
        step();
        pcon_wr = 0;
        check("R11 write upper bits read 0", pcon_rdata, 3);
        // R10 brown-out clears bit 0 only, restarts sequence
        bor_pulse = 1;
        step();
        bor_pulse = 0;
        check("R10 bor pcon", pcon_rdata, 2);
        check("R12 bor restart", seq_state, 1);
        measure(2'd1, n);
        check("R12 pwrt after bor", n, P);
        // R12 restart in the middle of OST
        repeat (100) step();
        check("R12 in ost", seq_state, 2);
        pulse_por();
        check("R10 por keeps bor bit", pcon_rdata, 0);
        measure(2'd1, n);
        check("R12 pwrt full after restart", n, P);
        measure(2'd2, n);
        check("R12 ost full after restart", n, O);
        // R11 write colliding with brown-out
        pcon_wr = 1; pcon_wdata = 8'h03; bor_pulse = 1;
        step();
        pcon_wr = 0; bor_pulse = 0;
        check("R11 event beats write", pcon_rdata, 2);
        pcon_wr = 1; pcon_wdata = 8'h03;
        step();
        pcon_wr = 0;
        // R10 both pulses together
        por_pulse = 1; bor_pulse = 1;
        step();
        por_pulse = 0; bor_pulse = 0;
        check("R10 both events", pcon_rdata, 0);
        measure(2'd1, n);
        measure(2'd2, n);
        check("R10 back to run", seq_state, 3);

        // R8 watchdog reset while awake
        wdt_pulse = 1;
        step();
        wdt_pulse = 0;
        check("R8 to cleared", flag_to, 0);
        check("R8 pd kept 1", flag_pd, 1);
        check("R8 idle cycle", seq_state, 0);
        step();
        check("R8 run again", seq_state, 3);

        // R6 master reset during sleep
        cpu_sleep = 1; mclr_n = 0;
        step();
        check("R6 sleep mclr to", flag_to, 1);
        check("R6 sleep mclr pd", flag_pd, 0);
        check("R6 idle", seq_state, 0);
        mclr_n = 1; cpu_sleep = 0;
        step();
        check("R6 run after release", seq_state, 3);
        // R8 watchdog with pd=0 keeps pd
        wdt_pulse = 1;
        step();
        wdt_pulse = 0;
        check("R8 pd kept 0", {flag_to, flag_pd}, 0);
        step();
        // R6 master reset while awake keeps flags
        pcon_wr = 1; pcon_wdata = 8'h03;
        step();
        pcon_wr = 0;
        mclr_n = 0;
        step();
        check("R6 awake mclr idle", seq_state, 0);
        check("R6 awake flags kept", {pcon_rdata, flag_to, flag_pd}, 12);
        mclr_n = 1;
        step();
        check("R6 awake run", seq_state, 3);

        // R7 wake in crystal mode
        cfg_osc_mode = 3'd1; cpu_sleep = 1; wake_pulse = 1;
        step();
        wake_pulse = 0; cpu_sleep = 0;
        check("R7 wake to ost", seq_state, 2);
        measure(2'd2, n);
        check("R7 wake ost len", n, O);
        check("R7 wake run", seq_state, 3);
        // R7 wake in external-clock mode
        cfg_osc_mode = 3'd4; cpu_sleep = 1; wake_pulse = 1;
        step();
        wake_pulse = 0;
        check("R7 non-crystal stays run", seq_state, 3);
        step();
        check("R7 non-crystal still run", seq_state, 3);

        // R9 watchdog wake-up in HS
        cfg_osc_mode = 3'd2; wdt_pulse = 1;
        step();
        wdt_pulse = 0; cpu_sleep = 0;
        check("R9 flags", {flag_to, flag_pd}, 0);
        check("R9 ost", seq_state, 2);
        measure(2'd2, n);
        check("R9 ost len", n, O);
        check("R9 run", seq_state, 3);

        finish_run();
    end

endmodule